// File: doc/BRIEF.md
# Embedded Core Test Wrapper

This block surrounds a small embedded logic core with a test collar. Every core input and every core output passes through a boundary cell. A three-bit instruction register selects one of several wrapper modes. In transparent operation the core runs normally. In inward test the cells drive the core and observe its outputs. In outward test the cells drive the wrapper's own output pins so that surrounding interconnect can be checked. In isolation both sides are clamped to fixed values and tristate pins are released.

A serial port carries a data input, a data output and four controls: select, capture, shift and update. It loads either the instruction register or the data register that the current instruction picks. That data register is either the boundary chain or a one-bit bypass. Every register follows the same sequence. A parallel capture fills its shift stage, serial shifting moves data from input to output, and an update strobe copies the shift stage into a separate held stage. One instruction also hooks the boundary chain to a parallel test-access input and output. This lets the chain load at the same time as the serial port runs through the bypass.

Top module: `core_test_wrapper`

## Requirements
- R1: A synchronous active-high reset loads instruction 000 and clears every shift and update stage. After reset `to_core` equals `pin_in`, `pin_out` equals `core_out`, `pin_oe` is all ones, and `wso` reads 0 with `wsel` low.
- R2: With instruction 000, 001 or an unused code (110, 111), the wrapper is transparent (`to_core`=`pin_in`, `pin_out`=`core_out`). The data path then goes through the bypass bit: one shift cycle delays `wsi` to `wso`, and a capture loads 0.
- R3: The instruction register is 3 bits wide and is accessed when `wsel`=1. Capture loads the current instruction. Shift moves the register left with `wsi` entering bit 0, and `wso` shows bit 2. The shifted code takes effect only on an update strobe.
- R4: Instruction 010 (inward test) drives `to_core` from the input cells' update stages, passes `core_out` to `pin_out`, and places the boundary chain on the serial data path.
- R5: Instruction 011 (outward test) drives `pin_out` from the output cells' update stages, holds `to_core` at the parameter ISO_IN, and places the boundary chain on the serial data path.
- R6: Instruction 100 (isolation) holds `to_core` at ISO_IN and `pin_out` at ISO_OUT. `pin_oe` is 0 for every output marked in OUT_TRI and 1 for the others, and the serial data path goes through the bypass.
- R7: The boundary chain has N_IN+N_OUT cells, ordered from the serial input: input cells 0..N_IN-1, then output cells 0..N_OUT-1; `wso` shows output cell N_OUT-1. A capture loads `pin_in` into the input cells and `core_out` into the output cells.
- R8: Boundary update stages change only on an update strobe with `wsel`=0 under instruction 010, 011 or 101. They hold steady while data shifts.
- R9: Instruction 101 behaves as inward test, but the chain takes its shift data from `tam_in`. `tam_out` shows the last output cell, and `wso` runs through the bypass. Under every other instruction `tam_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wsi | input | 1 | Serial data input |
| wsel | input | 1 | 1 selects instruction register, 0 selects data register |
| shift_en | input | 1 | Serial shift of the selected register |
| capture_en | input | 1 | Parallel capture into the selected register |
| update_en | input | 1 | Copy shift stage into update stage |
| wso | output | 1 | Serial data output |
| tam_in | input | 1 | Parallel test-access scan input |
| tam_out | output | 1 | Parallel test-access scan output |
| pin_in | input | N_IN | Signals arriving at the wrapper input terminals |
| to_core | output | N_IN | Signals delivered to the core inputs |
| core_out | input | N_OUT | Signals produced by the core outputs |
| pin_out | output | N_OUT | Signals driven on the wrapper output terminals |
| pin_oe | output | N_OUT | Output enable per wrapper output terminal |

## Verification
The assertions assume that the controls are used one at a time. Capture and shift are never asserted together, and the serial select changes only between register accesses. The bypass timing property also relies on the instruction staying unchanged across a data shift, which holds because data accesses keep `wsel` low and cannot alter the instruction. The stimulus sequences loads, shifts and updates as separate cycles, so every stimulus stays inside these assumptions. It changes the pin and core values only between accesses.

// File: rtl/cw_pkg.sv
package cw_pkg;
   localparam int IR_W = 3;

   localparam logic [IR_W-1:0] OP_NORMAL  = 3'b000;
   localparam logic [IR_W-1:0] OP_BYPASS  = 3'b001;
   localparam logic [IR_W-1:0] OP_INWARD  = 3'b010;
   localparam logic [IR_W-1:0] OP_OUTWARD = 3'b011;
   localparam logic [IR_W-1:0] OP_ISOLATE = 3'b100;
   localparam logic [IR_W-1:0] OP_TAMTEST = 3'b101;

   typedef struct packed {
      logic core_drive;  // update stages drive core inputs
      logic pin_drive;   // update stages drive output pins
      logic iso_in;      // core inputs clamped
      logic iso_out;     // output pins clamped / released
      logic tam;         // chain fed from parallel access port
      logic chain_sel;   // chain sits on serial data path
      logic chain_act;   // chain responds to controls
   } cw_mode_t;

   function automatic cw_mode_t cw_decode(input logic [IR_W-1:0] op);
      cw_mode_t m;
      m = '0;
      case (op)
         OP_INWARD: begin
            m.core_drive = 1'b1;
            m.chain_sel  = 1'b1;
            m.chain_act  = 1'b1;
         end
         OP_OUTWARD: begin
            m.pin_drive = 1'b1;
            m.iso_in    = 1'b1;
            m.chain_sel = 1'b1;
            m.chain_act = 1'b1;
         end
         OP_ISOLATE: begin
            m.iso_in  = 1'b1;
            m.iso_out = 1'b1;
         end
         OP_TAMTEST: begin
            m.core_drive = 1'b1;
            m.tam        = 1'b1;
            m.chain_act  = 1'b1;
         end
         default: m = '0;
      endcase
      return m;
   endfunction
endpackage

// File: rtl/cw_instr_reg.sv
module cw_instr_reg
   import cw_pkg::*;
#(
   parameter logic [IR_W-1:0] RST_OP = OP_NORMAL
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            sel,
   input  logic            cap,
   input  logic            shf,
   input  logic            upd,
   input  logic            si,
   output logic            so,
   output logic [IR_W-1:0] ir_q
);
   logic [IR_W-1:0] ir_sh;

   always_ff @(posedge clk) begin
      if (rst) begin
         ir_sh <= '0;
         ir_q  <= RST_OP;
      end else if (sel) begin
         if (cap)
            ir_sh <= ir_q;
         else if (shf)
            ir_sh <= {ir_sh[IR_W-2:0], si};
         if (upd)
            ir_q <= ir_sh;
      end
   end

   assign so = ir_sh[IR_W-1];
endmodule

// File: rtl/cw_bypass.sv
module cw_bypass (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic cap,
   input  logic shf,
   input  logic si,
   output logic so
);
   always_ff @(posedge clk) begin
      if (rst)
         so <= 1'b0;
      else if (en) begin
         if (cap)
            so <= 1'b0;
         else if (shf)
            so <= si;
      end
   end
endmodule

// File: rtl/cw_cell.sv
module cw_cell (
   input  logic clk,
   input  logic rst,
   input  logic cap,
   input  logic shf,
   input  logic upd,
   input  logic cap_d,
   input  logic si,
   output logic sh_q,
   output logic upd_q
);
   always_ff @(posedge clk) begin
      if (rst) begin
         sh_q  <= 1'b0;
         upd_q <= 1'b0;
      end else begin
         if (cap)
            sh_q <= cap_d;
         else if (shf)
            sh_q <= si;
         if (upd)
            upd_q <= sh_q;
      end
   end
endmodule

// File: rtl/cw_boundary_chain.sv
module cw_boundary_chain #(
   parameter int N_IN  = 4,
   parameter int N_OUT = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cap,
   input  logic             shf,
   input  logic             upd,
   input  logic             si,
   input  logic [N_IN-1:0]  pin_in,
   input  logic [N_OUT-1:0] core_out,
   output logic [N_IN-1:0]  in_upd,
   output logic [N_OUT-1:0] out_upd,
   output logic             so
);
   localparam int LEN = N_IN + N_OUT;

   logic [LEN-1:0] sh;
   logic [LEN-1:0] up;
   logic [LEN-1:0] cd;
   logic [LEN-1:0] sin;

   assign cd = {core_out, pin_in};

   for (genvar j = 0; j < LEN; j++) begin : g_cell
      if (j == 0) begin : g_head
         assign sin[j] = si;
      end else begin : g_link
         assign sin[j] = sh[j-1];
      end
      cw_cell u_cell (
         .clk   (clk),
         .rst   (rst),
         .cap   (cap),
         .shf   (shf),
         .upd   (upd),
         .cap_d (cd[j]),
         .si    (sin[j]),
         .sh_q  (sh[j]),
         .upd_q (up[j])
      );
   end

   assign in_upd  = up[N_IN-1:0];
   assign out_upd = up[LEN-1:N_IN];
   assign so      = sh[LEN-1];
endmodule

// File: rtl/core_test_wrapper.sv
module core_test_wrapper
   import cw_pkg::*;
#(
   parameter int               N_IN    = 4,
   parameter int               N_OUT   = 4,
   parameter logic [N_IN-1:0]  ISO_IN  = 4'hA,
   parameter logic [N_OUT-1:0] ISO_OUT = 4'h5,
   parameter logic [N_OUT-1:0] OUT_TRI = 4'hC
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wsi,
   input  logic             wsel,
   input  logic             shift_en,
   input  logic             capture_en,
   input  logic             update_en,
   output logic             wso,
   input  logic             tam_in,
   output logic             tam_out,
   input  logic [N_IN-1:0]  pin_in,
   output logic [N_IN-1:0]  to_core,
   input  logic [N_OUT-1:0] core_out,
   output logic [N_OUT-1:0] pin_out,
   output logic [N_OUT-1:0] pin_oe
);
   if (N_IN < 1) begin : g_bad_in
      $error("core_test_wrapper: N_IN must be at least 1");
   end
   if (N_OUT < 1) begin : g_bad_out
      $error("core_test_wrapper: N_OUT must be at least 1");
   end

   cw_mode_t        mode;
   logic [IR_W-1:0] ir_q;
   logic            ir_so;
   logic            byp_so;
   logic            chain_so;
   logic            chain_si;
   logic            dr_act;
   logic [N_IN-1:0]  in_upd;
   logic [N_OUT-1:0] out_upd;
   logic            tam_on;
   logic            byp_on;

   assign mode     = cw_decode(ir_q);
   assign dr_act   = ~wsel & mode.chain_act;
   assign chain_si = mode.tam ? tam_in : wsi;
   assign tam_on   = mode.tam;
   assign byp_on   = ~mode.chain_sel;

   cw_instr_reg #(.RST_OP(OP_NORMAL)) u_ir (
      .clk  (clk),
      .rst  (rst),
      .sel  (wsel),
      .cap  (capture_en),
      .shf  (shift_en),
      .upd  (update_en),
      .si   (wsi),
      .so   (ir_so),
      .ir_q (ir_q)
   );

   cw_bypass u_byp (
      .clk (clk),
      .rst (rst),
      .en  (~wsel),
      .cap (capture_en),
      .shf (shift_en),
      .si  (wsi),
      .so  (byp_so)
   );

   cw_boundary_chain #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chain (
      .clk      (clk),
      .rst      (rst),
      .cap      (dr_act & capture_en),
      .shf      (dr_act & shift_en),
      .upd      (dr_act & update_en),
      .si       (chain_si),
      .pin_in   (pin_in),
      .core_out (core_out),
      .in_upd   (in_upd),
      .out_upd  (out_upd),
      .so       (chain_so)
   );

   for (genvar i = 0; i < N_IN; i++) begin : g_in_term
      always_comb begin
         if (mode.iso_in)
            to_core[i] = ISO_IN[i];
         else if (mode.core_drive)
            to_core[i] = in_upd[i];
         else
            to_core[i] = pin_in[i];
      end
   end

   for (genvar k = 0; k < N_OUT; k++) begin : g_out_term
      always_comb begin
         if (mode.iso_out)
            pin_out[k] = ISO_OUT[k];
         else if (mode.pin_drive)
            pin_out[k] = out_upd[k];
         else
            pin_out[k] = core_out[k];
         pin_oe[k] = ~(mode.iso_out & OUT_TRI[k]);
      end
   end

   assign wso     = wsel ? ir_so : (mode.chain_sel ? chain_so : byp_so);
   assign tam_out = mode.tam & chain_so;
endmodule

// File: rtl/cw_checker.sv
module cw_checker
   import cw_pkg::*;
#(
   parameter int               N_IN    = 4,
   parameter int               N_OUT   = 4,
   parameter logic [N_IN-1:0]  ISO_IN  = 4'hA,
   parameter logic [N_OUT-1:0] ISO_OUT = 4'h5,
   parameter logic [N_OUT-1:0] OUT_TRI = 4'hC
) (
   input logic             clk,
   input logic             rst,
   input logic             wsel,
   input logic             shift_en,
   input logic             capture_en,
   input logic             update_en,
   input logic             wsi,
   input logic             wso,
   input logic             tam_out,
   input logic             tam_on,
   input logic             byp_on,
   input logic [IR_W-1:0]  ir_q,
   input logic [N_IN-1:0]  pin_in,
   input logic [N_IN-1:0]  to_core,
   input logic [N_OUT-1:0] core_out,
   input logic [N_OUT-1:0] pin_out,
   input logic [N_OUT-1:0] pin_oe,
   input logic [N_IN-1:0]  in_upd,
   input logic [N_OUT-1:0] out_upd
);
   AST_NORMAL_PASS: assert property (@(posedge clk) disable iff (rst)
      (ir_q == OP_NORMAL) |-> (to_core == pin_in && pin_out == core_out)); // R2

   AST_BYPASS_DELAY: assert property (@(posedge clk) disable iff (rst)
      (!wsel && shift_en && !capture_en && byp_on) |=> (wsel || !byp_on || wso == $past(wsi))); // R2

   AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(wsel && update_en) |=> $stable(ir_q)); // R3

   AST_OUTWARD_CLAMP: assert property (@(posedge clk) disable iff (rst)
      (ir_q == OP_OUTWARD) |-> (to_core == ISO_IN && pin_out == out_upd)); // R5

   AST_ISO_RELEASE: assert property (@(posedge clk) disable iff (rst)
      (ir_q == OP_ISOLATE) |-> (pin_oe == ~OUT_TRI && pin_out == ISO_OUT)); // R6

   AST_UPD_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(update_en && !wsel) |=> ($stable(in_upd) && $stable(out_upd))); // R8

   AST_TAM_IDLE: assert property (@(posedge clk) disable iff (rst)
      !tam_on |-> (tam_out == 1'b0)); // R9
endmodule

bind core_test_wrapper cw_checker #(
   .N_IN(N_IN), .N_OUT(N_OUT), .ISO_IN(ISO_IN), .ISO_OUT(ISO_OUT), .OUT_TRI(OUT_TRI)
) u_chk (.*);

// File: tb/core_test_wrapper_tb.sv
module core_test_wrapper_tb;
   localparam int NI = 4;
   localparam int NO = 4;
   localparam int L  = NI + NO;
   localparam logic [NI-1:0] E_ISO_IN  = 4'hA;
   localparam logic [NO-1:0] E_ISO_OUT = 4'h5;
   localparam logic [NO-1:0] E_TRI     = 4'hC;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic wsi = 0, wsel = 0, shift_en = 0, capture_en = 0, update_en = 0, tam_in = 0;
   logic [NI-1:0] pin_in = 4'h3;
   logic [NO-1:0] core_out = 4'hC;
   logic wso, tam_out;
   logic [NI-1:0] to_core;
   logic [NO-1:0] pin_out, pin_oe;

   int n_chk = 0;
   int n_err = 0;

   always #5 clk = ~clk;

   core_test_wrapper u_dut (
      .clk(clk), .rst(rst), .wsi(wsi), .wsel(wsel), .shift_en(shift_en),
      .capture_en(capture_en), .update_en(update_en), .wso(wso),
      .tam_in(tam_in), .tam_out(tam_out), .pin_in(pin_in), .to_core(to_core),
      .core_out(core_out), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // behavioural reference state
   logic [2:0]    m_ir  = 3'd0;
   logic [2:0]    m_irs = 3'd0;
   logic          m_byp = 1'b0;
   bit            m_ch[$];
   logic [NI-1:0] m_iu = '0;
   logic [NO-1:0] m_ou = '0;

   function automatic bit chain_live(input logic [2:0] op);
      return (op == 3'd2 || op == 3'd3 || op == 3'd5);
   endfunction

   initial for (int k = 0; k < L; k++) m_ch.push_back(1'b0);

   always @(posedge clk) begin : p_model
      logic [2:0] old_irs;
      bit snap[$];
      if (rst) begin
         m_ir = 0; m_irs = 0; m_byp = 0; m_iu = 0; m_ou = 0;
         m_ch = {};
         for (int k = 0; k < L; k++) m_ch.push_back(1'b0);
      end else if (wsel) begin
         old_irs = m_irs;
         if (capture_en) m_irs = m_ir;
         else if (shift_en) m_irs = {m_irs[1:0], wsi};
         if (update_en) m_ir = old_irs;
      end else begin
         snap = m_ch;
         if (capture_en) m_byp = 1'b0;
         else if (shift_en) m_byp = wsi;
         if (chain_live(m_ir)) begin
            if (capture_en) begin
               m_ch = {};
               for (int k = 0; k < NI; k++) m_ch.push_back(pin_in[k]);
               for (int k = 0; k < NO; k++) m_ch.push_back(core_out[k]);
            end else if (shift_en) begin
               m_ch.push_front((m_ir == 3'd5) ? tam_in : wsi);
               void'(m_ch.pop_back());
            end
            if (update_en) begin
               for (int k = 0; k < NI; k++) m_iu[k] = snap[k];
               for (int k = 0; k < NO; k++) m_ou[k] = snap[NI + k];
            end
         end
      end
   end

   always @(negedge clk) begin : p_compare
      logic [NI-1:0] e_core;
      logic [NO-1:0] e_pout, e_oe;
      logic e_wso, e_tam;
      if (!rst) begin
         e_core = (m_ir == 3'd3 || m_ir == 3'd4) ? E_ISO_IN :
                  (m_ir == 3'd2 || m_ir == 3'd5) ? m_iu : pin_in;
         e_pout = (m_ir == 3'd4) ? E_ISO_OUT : (m_ir == 3'd3) ? m_ou : core_out;
         e_oe   = (m_ir == 3'd4) ? ~E_TRI : '1;
         e_wso  = wsel ? m_irs[2] : ((m_ir == 3'd2 || m_ir == 3'd3) ? m_ch[L-1] : m_byp);
         e_tam  = (m_ir == 3'd5) ? m_ch[L-1] : 1'b0;
         chk("R2/R4/R5/R6/R9 to_core", to_core, e_core);
         chk("R2/R5/R6 pin_out", pin_out, e_pout);
         chk("R6 pin_oe", pin_oe, e_oe);
         chk("R3/R7/R2 wso", wso, e_wso);
         chk("R9 tam_out", tam_out, e_tam);
      end
   end

   task automatic tick(input logic s, input logic sh, input logic cp, input logic up, input logic d);
      wsel = s; shift_en = sh; capture_en = cp; update_en = up; wsi = d;
      @(negedge clk);
      #1;
   endtask

   task automatic idle();
      tick(0, 0, 0, 0, 0);
   endtask

   task automatic load_ir(input logic [2:0] code);
      for (int b = 2; b >= 0; b--) tick(1, 1, 0, 0, code[b]);
      tick(1, 0, 0, 1, 0);
      idle();
   endtask

   task automatic scan_dr(input logic [L-1:0] val, input bit via_tam);
      for (int j = L - 1; j >= 0; j--) begin
         tam_in = via_tam ? val[j] : 1'b0;
         tick(0, 1, 0, 0, via_tam ? 1'b0 : val[j]);
      end
      tam_in = 0;
      tick(0, 0, 0, 1, 0);
      idle();
   endtask

   initial begin : p_watchdog
      #2000000;
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin : p_main
      logic [L-1:0] cap_v;
      repeat (3) tick(0, 0, 0, 0, 0);
      rst = 0;
      idle();
      // R1 reset state
      chk("R1 to_core", to_core, pin_in);
      chk("R1 pin_out", pin_out, core_out);
      chk("R1 pin_oe", pin_oe, 4'hF);
      chk("R1 wso", wso, 1'b0);

      // R2 bypass instruction
      load_ir(3'b001);
      tick(0, 1, 0, 0, 1);
      chk("R2 bypass one", wso, 1'b1);
      tick(0, 1, 0, 0, 0);
      chk("R2 bypass zero", wso, 1'b0);
      tick(0, 1, 0, 0, 1);
      tick(0, 0, 1, 0, 0);
      chk("R2 bypass capture", wso, 1'b0);
      // R2 unused code
      load_ir(3'b111);
      pin_in = 4'h9; core_out = 4'h6; idle();
      chk("R2 unused to_core", to_core, 4'h9);
      chk("R2 unused pin_out", pin_out, 4'h6);

      // R3 instruction register capture and shift
      load_ir(3'b010);
      tick(1, 0, 1, 0, 0);
      chk("R3 ir capture", wso, 1'b0);
      tick(1, 1, 0, 0, 1);
      chk("R3 ir shift a", wso, 1'b1);
      tick(1, 1, 0, 0, 0);
      chk("R3 ir shift b", wso, 1'b0);
      tick(1, 1, 0, 0, 1);
      chk("R3 ir no update", to_core, 4'h0);
      load_ir(3'b010);

      // R4 inward test
      scan_dr({4'b0000, 4'b1011}, 0);
      pin_in = 4'h4; core_out = 4'h7; idle();
      chk("R4 to_core", to_core, 4'b1011);
      chk("R4 pin_out", pin_out, 4'h7);

      // R8 hold during shift
      for (int s = 0; s < L; s++) begin
         pin_in = 4'(s);
         tick(0, 1, 0, 0, s[0]);
         chk("R8 hold", to_core, 4'b1011);
      end
      idle();

      // R7 capture and chain order
      pin_in = 4'h6; core_out = 4'h9;
      tick(0, 0, 1, 0, 0);
      cap_v = {core_out, pin_in};
      for (int s = 0; s < L; s++) begin
         chk("R7 order", wso, cap_v[L-1-s]);
         tick(0, 1, 0, 0, 0);
      end
      idle();

      // R5 outward test
      load_ir(3'b011);
      scan_dr({4'b0110, 4'b0000}, 0);
      chk("R5 pin_out", pin_out, 4'b0110);
      chk("R5 to_core", to_core, E_ISO_IN);

      // R6 isolation
      load_ir(3'b100);
      chk("R6 to_core", to_core, E_ISO_IN);
      chk("R6 pin_out", pin_out, E_ISO_OUT);
      chk("R6 pin_oe", pin_oe, 4'b0011);
      tick(0, 1, 0, 0, 1);
      chk("R6 bypass", wso, 1'b1);
      idle();

      // R9 parallel access test
      load_ir(3'b101);
      scan_dr(8'b1000_1101, 1);
      chk("R9 to_core", to_core, 4'b1101);
      chk("R9 tam_out", tam_out, 1'b1);
      chk("R9 wso bypass", wso, 1'b0);
      load_ir(3'b000);
      chk("R9 tam idle", tam_out, 1'b0);
      pin_in = 4'h2; core_out = 4'hE; idle();
      chk("R2 normal to_core", to_core, 4'h2);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule